// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped First-Level Cache

This block is a small fully associative store placed next to a direct-mapped first-level cache. Every line that the first-level cache displaces is handed to it through an eviction port and kept, with its address, data and dirty flag. When the first-level cache misses, it presents the missing line address on the lookup port before going further out. If the buffer holds that line, it returns the data one cycle later and takes the line the first-level cache is giving up in exchange. If the buffer misses, it issues a read to the next level.

When the buffer is full, an incoming line overwrites the oldest slot, chosen by a round-robin pointer. If that slot held modified data, the buffer issues a write request to the next level. This gives the addresses that fight over one first-level index some extra associativity without making the primary array any larger.

Top module: `victimBuffer`

## Requirements
- R1: After reset the buffer holds no lines, `respValid` and `l2ReqValid` are low, and both `lookupReady` and `evictReady` are high.
- R2: A line accepted on the eviction port is later found by a lookup of the same tag and index, which returns its data and dirty flag.
- R3: A lookup accepted at a clock edge raises `respValid` for exactly one cycle after that edge. On a hit, `respHit` is 1, `respData` and `respDirty` carry the stored line, and no next-level request is issued.
- R4: A lookup that misses gives `respHit` = 0 and, in the same cycle as the response, a next-level read (`l2ReqWrite` = 0) whose `l2ReqAddr` is `{tag, index}`, with the tag in the upper bits.
- R5: On a hit with `vicValid` = 1, the hit slot is overwritten by the displaced line `{vicTag, lookupIdx}` with `vicData` and `vicDirty`. A later lookup of the line that was returned misses.
- R6: On a hit with `vicValid` = 0, the hit slot is freed, so a later lookup of that line misses.
- R7: An inserted line goes to the lowest-numbered free slot. When no slot is free, it goes to the slot named by a replacement pointer that starts at 0 after reset and advances by one, wrapping, on each such replacement. The line that was overwritten is no longer found.
- R8: A replacement that overwrites a dirty line issues a next-level write carrying that line's `{tag, index}` address and data. Overwriting a clean line issues no next-level request.
- R9: At most one operation is accepted per cycle. When `lookupValid` is high, `evictReady` is low, so a lookup wins over a simultaneous eviction.
- R10: While `l2ReqValid` is high and `l2ReqReady` is low, the request holds its address and kind, and both `lookupReady` and `evictReady` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evictValid | input | 1 | Displaced line offered for insertion |
| evictReady | output | 1 | Insertion accepted this cycle when high with evictValid |
| evictTag | input | TAG_W | Tag of the displaced line |
| evictIdx | input | IDX_W | Index of the displaced line |
| evictData | input | DATA_W | Data of the displaced line |
| evictDirty | input | 1 | Displaced line is modified |
| lookupValid | input | 1 | Lookup request after a first-level miss |
| lookupReady | output | 1 | Lookup accepted this cycle when high with lookupValid |
| lookupTag | input | TAG_W | Tag of the missing line |
| lookupIdx | input | IDX_W | Index of the missing line |
| vicValid | input | 1 | First-level slot holds a line to swap in on a hit |
| vicTag | input | TAG_W | Tag of that first-level line (its index is lookupIdx) |
| vicData | input | DATA_W | Data of that first-level line |
| vicDirty | input | 1 | That first-level line is modified |
| respValid | output | 1 | Lookup response, one cycle after acceptance |
| respHit | output | 1 | Response is a hit |
| respData | output | DATA_W | Line data returned on a hit |
| respDirty | output | 1 | Dirty flag of the returned line |
| l2ReqValid | output | 1 | Next-level request pending |
| l2ReqReady | input | 1 | Next level takes the request |
| l2ReqWrite | output | 1 | 1 = write-back of a dirty line, 0 = read for a miss |
| l2ReqAddr | output | TAG_W+IDX_W | Line address {tag, index} |
| l2ReqData | output | DATA_W | Write-back data |

## Verification
A corrupted tag, valid bit or dirty bit does not show at once. It shows at the next lookup of the affected address, as a wrong hit flag or wrong data one cycle after the lookup is accepted. A dirty bit that is lost shows only when that slot is chosen for replacement, as a missing write-back. A pointer that is off by one shows on the first replacement after the buffer fills, when the wrong line disappears. The stimulus therefore fills the buffer, replaces lines in turn and looks up the replaced lines again, so each kind of state error reaches the ports within a few operations.

// File: rtl/vcPkg.sv
`timescale 1ns/1ps
package vcPkg;
  // Strobes from control to datapath; slot fields are wide enough for up to 256 entries.
  typedef struct packed {
    logic       lookupFire;
    logic       hit;
    logic       keepVictim;
    logic       insertFire;
    logic       writeBack;
    logic [7:0] hitSlot;
    logic [7:0] insSlot;
  } vcStrobe_t;
endpackage

// File: rtl/vcDatapath.sv
`timescale 1ns/1ps
module vcDatapath
  import vcPkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int IDX_W   = 6,
  parameter int DATA_W  = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  vcStrobe_t         strb,
  input  logic [TAG_W-1:0]  evictTag,
  input  logic [IDX_W-1:0]  evictIdx,
  input  logic [DATA_W-1:0] evictData,
  input  logic              evictDirty,
  input  logic [TAG_W-1:0]  lookupTag,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic [TAG_W-1:0]  vicTag,
  input  logic [DATA_W-1:0] vicData,
  input  logic              vicDirty,
  input  logic              l2ReqReady,
  output logic              hitAny,
  output logic [SLOT_W-1:0] hitIdx,
  output logic              full,
  output logic [SLOT_W-1:0] freeIdx,
  output logic [ENTRIES-1:0] dirtyVec,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              respDirty,
  output logic              l2ReqValid,
  output logic              l2ReqWrite,
  output logic [ADDR_W-1:0] l2ReqAddr,
  output logic [DATA_W-1:0] l2ReqData
);
  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] dirtyQ;
  logic [ADDR_W-1:0]  addrQ [ENTRIES];
  logic [DATA_W-1:0]  dataQ [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  logic [ADDR_W-1:0] lookAddr;
  assign lookAddr = {lookupTag, lookupIdx};

  // One comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign hitVec[g] = validQ[g] && (addrQ[g] == lookAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hitVec[i]) hitIdx = SLOT_W'(i);
  end

  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!validQ[i]) freeIdx = SLOT_W'(i);
  end

  assign hitAny   = |hitVec;
  assign full     = &validQ;
  assign dirtyVec = dirtyQ;

  logic [SLOT_W-1:0] hSlot, iSlot;
  assign hSlot = strb.hitSlot[SLOT_W-1:0];
  assign iSlot = strb.insSlot[SLOT_W-1:0];

  // Entry storage: a swap rewrites the hit slot, an insertion writes the chosen slot
  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else if (strb.lookupFire && strb.hit) begin
      if (strb.keepVictim) begin
        addrQ[hSlot]  <= {vicTag, lookupIdx};
        dataQ[hSlot]  <= vicData;
        dirtyQ[hSlot] <= vicDirty;
      end else begin
        validQ[hSlot] <= 1'b0;
      end
    end else if (strb.insertFire) begin
      validQ[iSlot] <= 1'b1;
      dirtyQ[iSlot] <= evictDirty;
      addrQ[iSlot]  <= {evictTag, evictIdx};
      dataQ[iSlot]  <= evictData;
    end
  end

  // Lookup response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respData  <= '0;
      respDirty <= 1'b0;
    end else begin
      respValid <= strb.lookupFire;
      if (strb.lookupFire) begin
        respHit   <= strb.hit;
        respData  <= strb.hit ? dataQ[hSlot] : '0;
        respDirty <= strb.hit && dirtyQ[hSlot];
      end
    end
  end

  // Next-level request register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      l2ReqValid <= 1'b0;
      l2ReqWrite <= 1'b0;
      l2ReqAddr  <= '0;
      l2ReqData  <= '0;
    end else if (strb.writeBack) begin
      l2ReqValid <= 1'b1;
      l2ReqWrite <= 1'b1;
      l2ReqAddr  <= addrQ[iSlot];
      l2ReqData  <= dataQ[iSlot];
    end else if (strb.lookupFire && !strb.hit) begin
      l2ReqValid <= 1'b1;
      l2ReqWrite <= 1'b0;
      l2ReqAddr  <= lookAddr;
      l2ReqData  <= '0;
    end else if (l2ReqReady) begin
      l2ReqValid <= 1'b0;
    end
  end

  // R2: a line address lives in at most one slot
  p_unique_hit_r2: assert property (@(posedge clk) disable iff (!rstN) $onehot0(hitVec));
  // R3: a hit response comes with no next-level traffic
  p_hit_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> !l2ReqValid);
  // R4: a miss response comes with a read request
  p_miss_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |-> (l2ReqValid && !l2ReqWrite));
  // R8: a write-back only takes a slot that is valid and dirty
  p_wb_dirty_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeBack |-> (validQ[iSlot] && dirtyQ[iSlot]));
  // R10: a stalled request holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (l2ReqValid && !l2ReqReady) |=> (l2ReqValid && $stable(l2ReqAddr) && $stable(l2ReqWrite)));
endmodule

// File: rtl/vcControl.sv
`timescale 1ns/1ps
module vcControl
  import vcPkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  output logic               lookupReady,
  input  logic               evictValid,
  output logic               evictReady,
  input  logic               vicValid,
  input  logic               hitAny,
  input  logic [SLOT_W-1:0]  hitIdx,
  input  logic               full,
  input  logic [SLOT_W-1:0]  freeIdx,
  input  logic [ENTRIES-1:0] dirtyVec,
  input  logic               l2Busy,
  input  logic               respValid,
  output vcStrobe_t          strb
);
  logic [SLOT_W-1:0] ptrQ;
  logic lookupFire, insertFire;

  // Lookups win; nothing is accepted while a next-level request waits
  assign lookupReady = !l2Busy;
  assign evictReady  = !l2Busy && !lookupValid;
  assign lookupFire  = lookupValid && lookupReady;
  assign insertFire  = evictValid && evictReady;

  always_comb begin
    strb            = '0;
    strb.lookupFire = lookupFire;
    strb.hit        = hitAny;
    strb.keepVictim = vicValid;
    strb.insertFire = insertFire;
    strb.hitSlot    = 8'(hitIdx);
    strb.insSlot    = full ? 8'(ptrQ) : 8'(freeIdx);
    strb.writeBack  = insertFire && full && dirtyVec[ptrQ];
  end

  // Round-robin replacement pointer, advanced only by replacements
  always_ff @(posedge clk) begin
    if (!rstN)
      ptrQ <= '0;
    else if (insertFire && full)
      ptrQ <= (ptrQ == SLOT_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
  end

  // R3: response exactly one cycle after acceptance
  p_resp_latency_r3: assert property (@(posedge clk) disable iff (!rstN)
    lookupFire |=> respValid);
  p_resp_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    !lookupFire |=> !respValid);
  // R10: both ports stall behind a pending request
  p_stall_r10: assert property (@(posedge clk) disable iff (!rstN)
    l2Busy |-> (!lookupReady && !evictReady));
  // R9: never two operations in one cycle
  p_one_op_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(lookupFire && insertFire));
endmodule

// File: rtl/victimBuffer.sv
`timescale 1ns/1ps
module victimBuffer
  import vcPkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 20,
  parameter int IDX_W   = 6,
  parameter int DATA_W  = 32,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evictValid,
  output logic              evictReady,
  input  logic [TAG_W-1:0]  evictTag,
  input  logic [IDX_W-1:0]  evictIdx,
  input  logic [DATA_W-1:0] evictData,
  input  logic              evictDirty,
  input  logic              lookupValid,
  output logic              lookupReady,
  input  logic [TAG_W-1:0]  lookupTag,
  input  logic [IDX_W-1:0]  lookupIdx,
  input  logic              vicValid,
  input  logic [TAG_W-1:0]  vicTag,
  input  logic [DATA_W-1:0] vicData,
  input  logic              vicDirty,
  output logic              respValid,
  output logic              respHit,
  output logic [DATA_W-1:0] respData,
  output logic              respDirty,
  output logic              l2ReqValid,
  input  logic              l2ReqReady,
  output logic              l2ReqWrite,
  output logic [ADDR_W-1:0] l2ReqAddr,
  output logic [DATA_W-1:0] l2ReqData
);
  vcStrobe_t          strb;
  logic               hitAny, full;
  logic [SLOT_W-1:0]  hitIdx, freeIdx;
  logic [ENTRIES-1:0] dirtyVec;

  vcControl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupReady(lookupReady),
    .evictValid(evictValid), .evictReady(evictReady),
    .vicValid(vicValid), .hitAny(hitAny), .hitIdx(hitIdx),
    .full(full), .freeIdx(freeIdx), .dirtyVec(dirtyVec),
    .l2Busy(l2ReqValid), .respValid(respValid), .strb(strb)
  );

  vcDatapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .evictTag(evictTag), .evictIdx(evictIdx), .evictData(evictData), .evictDirty(evictDirty),
    .lookupTag(lookupTag), .lookupIdx(lookupIdx),
    .vicTag(vicTag), .vicData(vicData), .vicDirty(vicDirty),
    .l2ReqReady(l2ReqReady),
    .hitAny(hitAny), .hitIdx(hitIdx), .full(full), .freeIdx(freeIdx), .dirtyVec(dirtyVec),
    .respValid(respValid), .respHit(respHit), .respData(respData), .respDirty(respDirty),
    .l2ReqValid(l2ReqValid), .l2ReqWrite(l2ReqWrite), .l2ReqAddr(l2ReqAddr), .l2ReqData(l2ReqData)
  );

  // R1: nothing is pending straight after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(!rstN) |-> (!respValid && !l2ReqValid));
endmodule

// File: tb/tb_victimBuffer.sv
`timescale 1ns/1ps
module tb_victimBuffer;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic evictValid = 0, evictDirty = 0, lookupValid = 0, vicValid = 0, vicDirty = 0, l2ReqReady = 1;
  logic [19:0] evictTag = 0, lookupTag = 0, vicTag = 0;
  logic [5:0]  evictIdx = 0, lookupIdx = 0;
  logic [31:0] evictData = 0, vicData = 0;
  logic evictReady, lookupReady, respValid, respHit, respDirty, l2ReqValid, l2ReqWrite;
  logic [31:0] respData, l2ReqData;
  logic [25:0] l2ReqAddr;

  victimBuffer dut (
    .clk(clk), .rstN(rstN),
    .evictValid(evictValid), .evictReady(evictReady), .evictTag(evictTag), .evictIdx(evictIdx),
    .evictData(evictData), .evictDirty(evictDirty),
    .lookupValid(lookupValid), .lookupReady(lookupReady), .lookupTag(lookupTag), .lookupIdx(lookupIdx),
    .vicValid(vicValid), .vicTag(vicTag), .vicData(vicData), .vicDirty(vicDirty),
    .respValid(respValid), .respHit(respHit), .respData(respData), .respDirty(respDirty),
    .l2ReqValid(l2ReqValid), .l2ReqReady(l2ReqReady), .l2ReqWrite(l2ReqWrite),
    .l2ReqAddr(l2ReqAddr), .l2ReqData(l2ReqData)
  );

  int testsRun = 0, testsFailed = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string reqName(input int n);
    case (n)
      2: return "R2"; 3: return "R3"; 4: return "R4"; 5: return "R5";
      6: return "R6"; 7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  // l2Kind: 0 none, 1 read, 2 write
  typedef struct packed {
    logic        isLookup;
    logic [19:0] tag;
    logic [5:0]  idx;
    logic [31:0] data;
    logic        dirty;
    logic        vicV;
    logic [19:0] vTag;
    logic [31:0] vData;
    logic        vDirty;
    logic        expHit;
    logic [31:0] expData;
    logic        expDirty;
    logic [1:0]  l2Kind;
    logic [25:0] l2Addr;
    logic [31:0] l2Data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    // fill the four slots (R2, R7)
    '{1'b0, 20'd1, 6'd5, 32'h11, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd7},
    '{1'b0, 20'd2, 6'd5, 32'h22, 1'b1, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd7},
    '{1'b0, 20'd3, 6'd7, 32'h33, 1'b1, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd7},
    '{1'b0, 20'd4, 6'd9, 32'h44, 1'b1, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd7},
    // hit with swap-in of (5,5)
    '{1'b1, 20'd2, 6'd5, 32'h0, 1'b0, 1'b1, 20'd5, 32'h55, 1'b0, 1'b1, 32'h22, 1'b1, 2'd0, 26'd0, 32'h0, 4'd3},
    // swapped-in line found, slot released
    '{1'b1, 20'd5, 6'd5, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b1, 32'h55, 1'b0, 2'd0, 26'd0, 32'h0, 4'd5},
    // returned line is gone
    '{1'b1, 20'd2, 6'd5, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, {20'd2, 6'd5}, 32'h0, 4'd5},
    // released slot misses
    '{1'b1, 20'd5, 6'd5, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, {20'd5, 6'd5}, 32'h0, 4'd6},
    // free slot reused
    '{1'b0, 20'd6, 6'd1, 32'h66, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd7},
    // full: replaces slot 0 (clean), no write-back
    '{1'b0, 20'd7, 6'd2, 32'h77, 1'b1, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd8},
    '{1'b1, 20'd1, 6'd5, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, {20'd1, 6'd5}, 32'h0, 4'd7},
    // replaces slot 1 (clean)
    '{1'b0, 20'd8, 6'd3, 32'h88, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd0, 26'd0, 32'h0, 4'd8},
    // replaces slot 2 (dirty) -> write-back
    '{1'b0, 20'd9, 6'd4, 32'h99, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd2, {20'd3, 6'd7}, 32'h33, 4'd8},
    '{1'b1, 20'd7, 6'd2, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b1, 32'h77, 1'b1, 2'd0, 26'd0, 32'h0, 4'd2},
    '{1'b1, 20'd3, 6'd7, 32'h0, 1'b0, 1'b0, 20'd0, 32'h0, 1'b0, 1'b0, 32'h0, 1'b0, 2'd1, {20'd3, 6'd7}, 32'h0, 4'd7}
  };

  task automatic checkL2(input vec_t v);
    string r = reqName(int'(v.req));
    check(l2ReqValid == (v.l2Kind != 0), {r, " l2 valid"}, l2ReqValid, v.l2Kind != 0);
    if (v.l2Kind != 0) begin
      check(l2ReqWrite == (v.l2Kind == 2), {r, " l2 kind"}, l2ReqWrite, v.l2Kind == 2);
      check(l2ReqAddr == v.l2Addr, {r, " l2 addr"}, l2ReqAddr, v.l2Addr);
      if (v.l2Kind == 2) check(l2ReqData == v.l2Data, {r, " l2 data"}, l2ReqData, v.l2Data);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    // R1 reset state
    check(!respValid && !l2ReqValid, "R1 idle outputs", {respValid, l2ReqValid}, 0);
    check(lookupReady && evictReady, "R1 ready", {lookupReady, evictReady}, 3);

    for (int k = 0; k < NVEC; k++) begin
      vec_t v = VECS[k];
      @(negedge clk);
      if (v.isLookup) begin
        lookupValid = 1; lookupTag = v.tag; lookupIdx = v.idx;
        vicValid = v.vicV; vicTag = v.vTag; vicData = v.vData; vicDirty = v.vDirty;
      end else begin
        evictValid = 1; evictTag = v.tag; evictIdx = v.idx; evictData = v.data; evictDirty = v.dirty;
      end
      @(posedge clk); #1;
      lookupValid = 0; evictValid = 0; vicValid = 0;
      if (v.isLookup) begin
        check(respValid, "R3 response valid", respValid, 1);
        check(respHit == v.expHit, {reqName(int'(v.req)), " hit flag"}, respHit, v.expHit);
        if (v.expHit) begin
          check(respData == v.expData, {reqName(int'(v.req)), " data"}, respData, v.expData);
          check(respDirty == v.expDirty, "R2 dirty", respDirty, v.expDirty);
        end
      end
      checkL2(v);
      @(posedge clk); #1;
      check(!respValid, "R3 single-cycle response", respValid, 0);
    end

    // R9: simultaneous lookup and eviction; lookup wins
    @(negedge clk);
    lookupValid = 1; lookupTag = 20'd40; lookupIdx = 6'd0;
    evictValid = 1; evictTag = 20'd41; evictIdx = 6'd0; evictData = 32'hA1; evictDirty = 0;
    #1;
    check(lookupReady && !evictReady, "R9 priority", {lookupReady, evictReady}, 2);
    @(posedge clk); #1;
    lookupValid = 0; evictValid = 0;
    check(respValid && !respHit, "R9 lookup served", {respValid, respHit}, 2);
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1; lookupTag = 20'd41; lookupIdx = 6'd0;
    @(posedge clk); #1;
    lookupValid = 0;
    check(!respHit, "R9 eviction not taken", respHit, 0);
    @(posedge clk);

    // R10: stalled next-level request
    @(negedge clk);
    l2ReqReady = 0;
    lookupValid = 1; lookupTag = 20'd50; lookupIdx = 6'd3;
    @(posedge clk); #1;
    lookupValid = 0;
    repeat (3) @(posedge clk);
    #1;
    check(l2ReqValid && !l2ReqWrite, "R10 request held", {l2ReqValid, l2ReqWrite}, 2);
    check(l2ReqAddr == {20'd50, 6'd3}, "R10 address held", l2ReqAddr, {20'd50, 6'd3});
    check(!lookupReady && !evictReady, "R10 ports stalled", {lookupReady, evictReady}, 0);
    @(negedge clk) l2ReqReady = 1;
    @(posedge clk); #1;
    check(!l2ReqValid && lookupReady, "R10 release", {l2ReqValid, lookupReady}, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule